// File: doc/BRIEF.md
# Reflected-Gray Toggle-Cell Sequence Counter

This block is a small state counter that walks a fixed cycle of eight 3-bit codes in which neighbouring codes differ in one bit. Each state bit sits in its own toggle cell, a flop that inverts when its toggle input is high and keeps its value otherwise. A combinational stage looks at the present code, works out the code that must follow it, and raises the toggle input only on the bit that has to change.

The counter advances on each rising clock edge while the count enable is high and holds its code while the enable is low. A synchronous, active-high clear returns every bit to zero and wins over counting on the same edge. The registered code is the block's output, with no decode after the flops, so downstream logic sees a glitch-free value that changes in one bit per step.

Top module: `gray_toggle_counter`

## Requirements
- R1: With the code read as an unsigned number whose bit 2 is the most significant, each enabled edge moves the output along the cycle 0, 4, 5, 7, 6, 2, 3, 1 and from 1 back to 0.
- R2: On every enabled edge with the clear low, exactly one output bit changes.
- R3: While the count enable is low and the clear is low, a rising edge leaves the output unchanged.
- R4: A rising edge with the clear high sets the output to 0.
- R5: When the clear and the count enable are both high on the same edge, the output becomes 0, not the next code of the cycle.
- R6: After a clear, the first enabled edge gives 4 and the eighth enabled edge gives 0 again.
- R7: The output changes only at a rising clock edge; a change of the count enable between edges does not move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all toggle cells |
| clr | input | 1 | Synchronous clear, active high, priority over counting |
| en | input | 1 | Count enable, active high; low gates every toggle input to 0 |
| state | output | CNT_W (3) | Registered code of the counter |

## Verification
The clear and the count step can fall on the same edge: the bench raises both inputs together while the counter sits at a non-zero code (5) and also from the middle of a run, and judges the result as 0 rather than the code that would follow. The clear with the enable low and the enable alone are driven as separate vectors, so a design that lets the toggle path override the clear, or that clears only when idle, is told apart from a correct one.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  // default width of the counter code
  parameter int unsigned GTC_DEF_W = 3;

  // working width for the code arithmetic helpers
  localparam int unsigned GTC_CALC_W = 32;

  typedef logic [GTC_CALC_W-1:0] gtc_word_t;

  // converts a reflected Gray code into its binary rank
  function automatic gtc_word_t gtc_gray_to_bin(input gtc_word_t g);
    gtc_word_t b;
    b[GTC_CALC_W-1] = g[GTC_CALC_W-1];
    for (int i = GTC_CALC_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // converts a binary rank into its reflected Gray code
  function automatic gtc_word_t gtc_bin_to_gray(input gtc_word_t b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/gtc_toggle_cell.sv
module gtc_toggle_cell (
  input  logic clk,
  input  logic clr,
  input  logic tog,
  output logic q
);

  logic q_nxt;

  // next value: clear wins, a high toggle inverts, otherwise keep
  always_comb begin
    if (clr) begin
      q_nxt = 1'b0;
    end else if (tog) begin
      q_nxt = ~q;
    end else begin
      q_nxt = q;
    end
  end

  always_ff @(posedge clk) begin
    q <= q_nxt;
  end

endmodule

// File: rtl/gtc_step_logic.sv
module gtc_step_logic #(
  parameter int unsigned W = gtc_pkg::GTC_DEF_W
) (
  input  logic         en,
  input  logic [W-1:0] cur,
  output logic [W-1:0] tog
);

  import gtc_pkg::*;

  // mask of the W low bits in the working width
  localparam gtc_word_t RANK_MASK = gtc_word_t'((64'd1 << W) - 64'd1);

  gtc_word_t rank_now;
  gtc_word_t rank_nxt;
  logic [W-1:0] code_nxt;

  // the cycle walks the reflected Gray order backwards, wrapping mod 2^W
  always_comb begin
    rank_now = gtc_gray_to_bin(gtc_word_t'(cur));
    rank_nxt = (rank_now - gtc_word_t'(1)) & RANK_MASK;
    code_nxt = W'(gtc_bin_to_gray(rank_nxt));
  end

  // a bit toggles where present and next code differ, gated by enable
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tog
      assign tog[gi] = en & (cur[gi] ^ code_nxt[gi]);
    end
  endgenerate

endmodule

// File: rtl/gray_toggle_counter.sv
module gray_toggle_counter #(
  parameter int unsigned CNT_W = gtc_pkg::GTC_DEF_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] state
);

  logic [CNT_W-1:0] cell_q;
  logic [CNT_W-1:0] cell_tog;

  gtc_step_logic #(.W(CNT_W)) u_step (
    .en  (en),
    .cur (cell_q),
    .tog (cell_tog)
  );

  genvar gb;
  generate
    for (gb = 0; gb < CNT_W; gb++) begin : g_cell
      gtc_toggle_cell u_cell (
        .clk (clk),
        .clr (clr),
        .tog (cell_tog[gb]),
        .q   (cell_q[gb])
      );
    end
  endgenerate

  assign state = cell_q;

endmodule

// File: rtl/gtc_chk.sv
module gtc_chk #(
  parameter int unsigned W = 3
) (
  input logic         clk,
  input logic         clr,
  input logic         en,
  input logic [W-1:0] state
);

  localparam logic [W-1:0] TOP_CODE = W'(1) << (W - 1);

  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    primed <= 1'b1;
  end

  // R4
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!primed)
    clr |=> (state == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!primed || clr)
    !en |=> $stable(state));

  // R2
  single_flip_chk: assert property (@(posedge clk) disable iff (!primed || clr)
    en |=> ($countones(state ^ $past(state)) == 1));

  // R6
  zero_to_top_chk: assert property (@(posedge clk) disable iff (!primed || clr)
    (en && state == '0) |=> (state == TOP_CODE));

endmodule

bind gray_toggle_counter gtc_chk #(.W(CNT_W)) u_chk (
  .clk   (clk),
  .clr   (clr),
  .en    (en),
  .state (state)
);

// File: tb/test_gray_toggle_counter.sv
`timescale 1ns/1ps
module test_gray_toggle_counter;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gray_toggle_counter #(.CNT_W(3)) i_gray_toggle_counter (
    .clk   (clk),
    .clr   (clr),
    .en    (en),
    .state (state)
  );

  always #5 clk = ~clk;

  // vector: {clr, en, expected state after the edge}
  localparam int NV = 18;
  localparam logic [4:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0},  // R4 reset state
    {1'b0, 1'b1, 3'd4},  // R6 first step
    {1'b0, 1'b1, 3'd5},  // R1
    {1'b0, 1'b0, 3'd5},  // R3 hold
    {1'b0, 1'b1, 3'd7},  // R1
    {1'b0, 1'b1, 3'd6},
    {1'b0, 1'b0, 3'd6},  // R3
    {1'b0, 1'b1, 3'd2},
    {1'b0, 1'b1, 3'd3},
    {1'b0, 1'b1, 3'd1},
    {1'b0, 1'b1, 3'd0},  // R1 wrap
    {1'b0, 1'b1, 3'd4},
    {1'b0, 1'b1, 3'd5},
    {1'b1, 1'b1, 3'd0},  // R5 clear beats step
    {1'b0, 1'b1, 3'd4},
    {1'b0, 1'b1, 3'd5},
    {1'b1, 1'b0, 3'd0},  // R4 clear with enable low
    {1'b0, 1'b0, 3'd0}   // R3 hold at zero
  };

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (state !== exp) begin
      fails++;
      $display("FAIL %s state=%0d expected=%0d", req, state, exp);
    end
  endtask

  // drive between edges, sample just after the edge
  task automatic step(input logic c, input logic e);
    @(negedge clk);
    clr = c;
    en  = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [2:0] prev;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check("R1/R3/R4/R5 vector", VEC[i][2:0]);
    end

    // R6: eight enabled edges after a clear return to zero
    step(1'b1, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      prev = state;
      step(1'b0, 1'b1);
      if (k == 1) check("R6 first", 3'd4);
      // R2 one bit per step
      checks++;
      if ($countones(state ^ prev) != 1) begin
        fails++;
        $display("FAIL R2 flips=%0d expected=1", $countones(state ^ prev));
      end
    end
    check("R6 eighth", 3'd0);

    // R7: enable pulse between edges does not move the output
    step(1'b0, 1'b1);  // now at 4
    @(negedge clk);
    en = 1'b0;
    #1 en = 1'b1;
    #1 en = 1'b0;
    #1;
    check("R7 mid-cycle", 3'd4);
    @(posedge clk);
    #1;
    check("R7 idle edge", 3'd4);

    // R5 from a non-initial code with long run first
    step(1'b0, 1'b1);  // 5
    step(1'b0, 1'b1);  // 7
    step(1'b1, 1'b1);
    check("R5 at 7", 3'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule